// File: doc/BRIEF.md
# Register-Register Integer Execute Unit

This block runs 32-bit integer register-register instructions at a rate of one per clock. Each word presented on `instr` with `in_valid` high is split into its destination index, two source indices and two function fields. The two source indices select operands from an internal 32 x 32-bit register file. The unit computes one of ten results: add, subtract, bitwise AND/OR/XOR, signed less-than, unsigned less-than, and left, logical-right or arithmetic-right shift. The result is written back to the destination register on the next rising clock edge.

The instruction input is a valid/ready stream. `in_ready` is held high at all times, so the unit never applies back-pressure. Every cycle with `in_valid` high consumes exactly one word. When `in_valid` is low the word is ignored.

A word that is not one of the ten legal encodings raises `illegal` in the same cycle and writes nothing. A debug port reads any register combinationally. The same port can also preload a register, which is how a test environment seeds operands.

Top module: `rrx_core`

## Requirements
- R1: A word is executable only when bits [6:0] equal 7'b0110011. Any other value in those bits raises `illegal` (while `in_valid` is high) and leaves every register unchanged.
- R2: Fields are placed as follows: destination index in [11:7], first source index in [19:15], second source index in [24:20], function-3 in [14:12] and function-7 in [31:25]. Operands are the contents of the registers those indices name, not the index values themselves.
- R3: Function-7 0000000 with function-3 000 adds. Function-7 0100000 with function-3 000 subtracts (first minus second). Both keep only the low 32 bits, and overflow is discarded.
- R4: Function-7 0000000 with function-3 010 writes 1 when the first operand is less than the second as two's-complement values, otherwise 0.
- R5: Function-7 0000000 with function-3 011 writes 1 when the first operand is less than the second as unsigned values, otherwise 0.
- R6: Function-7 0000000 with function-3 111, 110 and 100 write the bitwise AND, OR and XOR respectively.
- R7: Function-7 0000000 with function-3 001 shifts left and function-3 101 shifts right logically, both filling with zeros. Function-7 0100000 with function-3 101 shifts right filling with bit 31 of the first operand. The shift distance is bits [4:0] of the second operand, and its upper bits are ignored.
- R8: Any function-7/function-3 pair other than the ten above raises `illegal` (while `in_valid` is high) and writes nothing.
- R9: Register 0 always reads as zero. A write whose destination index is 0 is discarded.
- R10: Only the destination register changes. It takes the result on the rising edge that ends the cycle where `in_valid` is high. Source registers keep their values, and nothing is written while `in_valid` is low.
- R11: A synchronous reset (`rst` high at a rising edge) clears every register to zero.
- R12: `in_ready` is always high, and one word is accepted on every cycle where `in_valid` is high.
- R13: The word 32'h00D60733 writes the sum of registers 12 and 13 into register 14.
- R14: `dbg_data` shows register `dbg_idx` combinationally. With `dbg_we` high, `dbg_wdata` is stored into register `dbg_idx` at the rising edge. An instruction write to the same register in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Always high, the unit never stalls |
| instr | input | 32 | Instruction word |
| illegal | output | 1 | Current valid word is not a legal encoding |
| dbg_idx | input | 5 | Debug register index |
| dbg_data | output | 32 | Contents of register `dbg_idx` |
| dbg_we | input | 1 | Debug preload strobe |
| dbg_wdata | input | 32 | Debug preload value |

## Verification
Directed words probe the edges of each operation: sums that wrap past the sign bit or past all ones, comparisons where the signed and unsigned answers differ, and shift distances of 0, 31 and values with junk in the upper bits. These separate a correct wrap, signedness and masking from a design that gets only the common case right. Separate words use register 0 as destination and source, and use a destination equal to a source, to expose writes that escape their target. Random words mix legal encodings with near-miss function fields and foreign opcodes. A behavioural model is compared on every word, and a full register scan after each phase catches stray writes.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

  localparam logic [6:0] OPC_REGREG = 7'b0110011;
  localparam logic [6:0] F7_BASE    = 7'b0000000;
  localparam logic [6:0] F7_ALT     = 7'b0100000;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLT, OP_SLTU, OP_XOR,
    OP_OR,  OP_AND, OP_SLL, OP_SRL,  OP_SRA
  } alu_op_e;

  typedef struct packed {
    logic [6:0] f7;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic [2:0] f3;
    logic [4:0] rd;
    logic [6:0] opc;
  } rr_word_t;

endpackage

// File: rtl/rrx_decode.sv
module rrx_decode
  import rrx_pkg::*;
(
  input  logic [31:0] word,
  output alu_op_e     op,
  output logic        legal,
  output logic [4:0]  rd,
  output logic [4:0]  rs1,
  output logic [4:0]  rs2
);
  rr_word_t f;

  always_comb begin
    f     = rr_word_t'(word);
    rd    = f.rd;
    rs1   = f.rs1;
    rs2   = f.rs2;
    op    = OP_ADD;
    legal = 1'b0;
    if (f.opc == OPC_REGREG) begin
      if (f.f7 == F7_BASE) begin
        legal = 1'b1;
        case (f.f3)
          3'b000:  op = OP_ADD;
          3'b001:  op = OP_SLL;
          3'b010:  op = OP_SLT;
          3'b011:  op = OP_SLTU;
          3'b100:  op = OP_XOR;
          3'b101:  op = OP_SRL;
          3'b110:  op = OP_OR;
          default: op = OP_AND;
        endcase
      end else if (f.f7 == F7_ALT) begin
        case (f.f3)
          3'b000: begin op = OP_SUB; legal = 1'b1; end
          3'b101: begin op = OP_SRA; legal = 1'b1; end
          default: legal = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rrx_alu.sv
module rrx_alu
  import rrx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0]  sh;
  logic            lt_s;
  logic            lt_u;

  always_comb begin
    sh   = b[SHW-1:0];
    lt_s = $signed(a) < $signed(b);
    lt_u = a < b;
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
      OP_XOR:  y = a ^ b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_SLL:  y = a << sh;
      OP_SRL:  y = a >> sh;
      OP_SRA:  y = XLEN'($signed(a) >>> sh);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rrx_regfile.sv
module rrx_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [$clog2(NREG)-1:0]    waddr,
  input  logic [XLEN-1:0]            wdata,
  input  logic                       pre_we,
  input  logic [$clog2(NREG)-1:0]    pre_addr,
  input  logic [XLEN-1:0]            pre_data,
  input  logic [$clog2(NREG)-1:0]    ra1,
  output logic [XLEN-1:0]            rd1,
  input  logic [$clog2(NREG)-1:0]    ra2,
  output logic [XLEN-1:0]            rd2,
  input  logic [$clog2(NREG)-1:0]    ra3,
  output logic [XLEN-1:0]            rd3
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst)
          regs[i] <= '0;
        else if (we && waddr == AW'(i))
          regs[i] <= wdata;
        else if (pre_we && pre_addr == AW'(i))
          regs[i] <= pre_data;
      end
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];
endmodule

// File: rtl/rrx_core.sv
module rrx_core
  import rrx_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] instr,
  output logic        illegal,
  input  logic [4:0]  dbg_idx,
  output logic [XLEN-1:0] dbg_data,
  input  logic        dbg_we,
  input  logic [XLEN-1:0] dbg_wdata
);
  alu_op_e          op;
  logic             legal;
  logic [4:0]       rd_i, rs1_i, rs2_i;
  logic [XLEN-1:0]  opa, opb, alu_res;
  logic             wr_en;

  rrx_decode u_dec (
    .word  (instr),
    .op    (op),
    .legal (legal),
    .rd    (rd_i),
    .rs1   (rs1_i),
    .rs2   (rs2_i)
  );

  rrx_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_en),
    .waddr    (rd_i),
    .wdata    (alu_res),
    .pre_we   (dbg_we),
    .pre_addr (dbg_idx),
    .pre_data (dbg_wdata),
    .ra1      (rs1_i),
    .rd1      (opa),
    .ra2      (rs2_i),
    .rd2      (opb),
    .ra3      (dbg_idx),
    .rd3      (dbg_data)
  );

  rrx_alu #(.XLEN(XLEN)) u_alu (
    .op (op),
    .a  (opa),
    .b  (opb),
    .y  (alu_res)
  );

  assign in_ready = 1'b1;
  assign illegal  = in_valid && !legal;
  assign wr_en    = in_valid && legal && (rd_i != 5'd0);
endmodule

// File: rtl/rrx_checker.sv
module rrx_checker
  import rrx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            illegal,
  input logic            wr_en,
  input alu_op_e         op,
  input logic [XLEN-1:0] alu_res,
  input logic [4:0]      dbg_idx,
  input logic [XLEN-1:0] dbg_data
);
  p_always_ready_r12: assert property (@(posedge clk) disable iff (rst)
    in_ready == 1'b1);

  p_no_write_on_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wr_en);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!illegal && !wr_en));

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
    (dbg_idx == 5'd0) |-> (dbg_data == '0));

  p_cleared_after_reset_r11: assert property (@(posedge clk)
    rst |=> (dbg_data == '0));

  p_compare_is_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_SLT || op == OP_SLTU)) |-> (alu_res[XLEN-1:1] == '0));
endmodule

bind rrx_core rrx_checker #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .illegal  (illegal),
  .wr_en    (wr_en),
  .op       (op),
  .alu_res  (alu_res),
  .dbg_idx  (dbg_idx),
  .dbg_data (dbg_data)
);

// File: tb/sim_rrx_core.sv
module sim_rrx_core;
  logic        clk = 1'b0;
  logic        rst, in_valid, in_ready, illegal, dbg_we;
  logic [31:0] instr, dbg_data, dbg_wdata;
  logic [4:0]  dbg_idx;
  int          errors = 0, checks = 0;
  bit          done = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  rrx_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .illegal(illegal), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata)
  );

  function automatic logic [31:0] enc(logic [6:0] f7, logic [2:0] f3,
                                      logic [4:0] rd, logic [4:0] s1, logic [4:0] s2);
    return {f7, s2, s1, f3, rd, 7'b0110011};
  endfunction

  function automatic bit is_legal(logic [31:0] w);
    if (w[6:0] != 7'b0110011) return 0;
    if (w[31:25] == 7'h00) return 1;
    if (w[31:25] == 7'h20 && (w[14:12] == 3'd0 || w[14:12] == 3'd5)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] ref_op(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    int sh = int'(b[4:0]);
    logic [31:0] r;
    case ({w[30], w[14:12]})
      4'b0000: r = a + b;
      4'b1000: r = a - b;
      4'b0010: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b0011: r = (a < b) ? 32'd1 : 32'd0;
      4'b0100: r = a ^ b;
      4'b0110: r = a | b;
      4'b0111: r = a & b;
      4'b0001: r = a << sh;
      4'b0101: r = a >> sh;
      default: begin
        r = a;
        for (int k = 0; k < sh; k++) r = {a[31], r[31:1]};
      end
    endcase
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic seed(int idx, logic [31:0] val);
    @(negedge clk);
    dbg_idx = 5'(idx); dbg_wdata = val; dbg_we = 1'b1;
    @(posedge clk); #1;
    dbg_we = 1'b0;
    if (idx != 0) model[idx] = val;
    @(negedge clk); #1;
    chk("R14 preload", dbg_data, model[idx]);
  endtask

  task automatic exec(logic [31:0] w, bit v, string req);
    logic [31:0] a, b, res;
    bit          lg;
    int          rd;
    lg = is_legal(w);
    rd = int'(w[11:7]);
    @(negedge clk);
    instr = w; in_valid = v;
    #1;
    a   = model[w[19:15]];
    b   = model[w[24:20]];
    res = ref_op(w, a, b);
    chk({req, " illegal flag"}, {31'd0, illegal}, {31'd0, (v && !lg)});
    chk("R12 ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (v && lg && rd != 0) model[rd] = res;
    @(negedge clk);
    dbg_idx = w[11:7];
    #1;
    chk(req, dbg_data, model[rd]);
  endtask

  task automatic scan(string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      dbg_idx = 5'(i);
      #1;
      chk(req, dbg_data, model[i]);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    rst = 1'b1; in_valid = 1'b0; instr = 32'd0;
    dbg_idx = 5'd0; dbg_we = 1'b0; dbg_wdata = 32'd0;
    // preload before reset: reset must clear it (R11)
    @(negedge clk); dbg_we = 1'b1; dbg_idx = 5'd3; dbg_wdata = 32'hDEAD_BEEF;
    @(negedge clk); dbg_we = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    scan("R11 reset clear");

    seed(12, 32'd5); seed(13, 32'd7);
    exec(32'h00D6_0733, 1, "R13 example add");
    scan("R10 sources untouched");

    seed(1, 32'h7FFF_FFFF); seed(2, 32'h0000_0001); seed(3, 32'hFFFF_FFFF);
    seed(4, 32'h8000_0000); seed(5, 32'hFFFF_FFE4); seed(6, 32'h0000_001F);
    seed(7, 32'hF0F0_1234);
    exec(enc(7'h00, 3'd0, 5'd10, 5'd1, 5'd2), 1, "R3 add signed wrap");
    exec(enc(7'h00, 3'd0, 5'd10, 5'd3, 5'd2), 1, "R3 add carry out");
    exec(enc(7'h20, 3'd0, 5'd10, 5'd0, 5'd2), 1, "R3 sub borrow");
    exec(enc(7'h20, 3'd0, 5'd10, 5'd4, 5'd2), 1, "R3 sub wrap");
    exec(enc(7'h00, 3'd2, 5'd11, 5'd3, 5'd2), 1, "R4 slt negative");
    exec(enc(7'h00, 3'd2, 5'd11, 5'd2, 5'd4), 1, "R4 slt vs min");
    exec(enc(7'h00, 3'd3, 5'd11, 5'd3, 5'd2), 1, "R5 sltu large");
    exec(enc(7'h00, 3'd3, 5'd11, 5'd2, 5'd4), 1, "R5 sltu small");
    exec(enc(7'h00, 3'd7, 5'd15, 5'd7, 5'd1), 1, "R6 and");
    exec(enc(7'h00, 3'd6, 5'd15, 5'd7, 5'd4), 1, "R6 or");
    exec(enc(7'h00, 3'd4, 5'd15, 5'd7, 5'd3), 1, "R6 xor");
    exec(enc(7'h00, 3'd1, 5'd16, 5'd7, 5'd5), 1, "R7 sll masked amount");
    exec(enc(7'h00, 3'd5, 5'd16, 5'd7, 5'd6), 1, "R7 srl by 31");
    exec(enc(7'h20, 3'd5, 5'd16, 5'd7, 5'd5), 1, "R7 sra masked amount");
    exec(enc(7'h20, 3'd5, 5'd16, 5'd4, 5'd6), 1, "R7 sra by 31");
    exec(enc(7'h00, 3'd5, 5'd16, 5'd7, 5'd0), 1, "R7 shift by zero");
    exec(enc(7'h00, 3'd0, 5'd17, 5'd2, 5'd7), 1, "R2 operand order");
    exec(enc(7'h20, 3'd0, 5'd17, 5'd7, 5'd2), 1, "R2 operand order sub");
    exec(enc(7'h00, 3'd0, 5'd0, 5'd1, 5'd7), 1, "R9 write to zero");
    exec(enc(7'h00, 3'd6, 5'd18, 5'd0, 5'd0), 1, "R9 zero operands");
    exec(enc(7'h00, 3'd0, 5'd7, 5'd7, 5'd7), 1, "R10 dest equals source");
    exec(enc(7'h00, 3'd0, 5'd19, 5'd1, 5'd1), 0, "R10 no write when idle");
    exec(enc(7'h00, 3'd0, 5'd19, 5'd1, 5'd1) ^ 32'h0000_0020, 1, "R1 wrong opcode");
    exec(enc(7'h20, 3'd1, 5'd19, 5'd1, 5'd2), 1, "R8 alt sll");
    exec(enc(7'h01, 3'd0, 5'd19, 5'd1, 5'd2), 1, "R8 foreign funct7");
    exec(enc(7'h20, 3'd7, 5'd19, 5'd1, 5'd2), 1, "R8 alt and");
    scan("R10 full scan");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      logic [6:0]  f7;
      int          pick = int'($urandom_range(0, 9));
      if (n % 60 == 0) seed(int'($urandom_range(1, 31)), $urandom());
      f7 = (pick < 5) ? 7'h00 : (pick < 8) ? 7'h20 : 7'($urandom());
      w  = enc(f7, 3'($urandom()), 5'($urandom()), 5'($urandom()), 5'($urandom()));
      if (pick == 9) w[6:0] = 7'($urandom());
      exec(w, ($urandom_range(0, 7) != 0), "R8 random mix");
    end
    scan("R10 final scan");

    done = 1;
    summary();
    $finish;
  end
endmodule